// File: doc/BRIEF.md
# SMRAM and TSEG Access Gate

This block decides, for every memory request, whether the target address reaches system RAM, goes out to the PCI side, or lands in a discard sink. It protects two pieces of system-management memory: the legacy graphics-hole window at 0xA0000–0xBFFFF, which can also be reached through a 128 KiB high alias at 0xFEDA0000, and a top-of-segment (TSEG) carve-out that sits directly below the end of low memory. Requests made in system-management mode (SMM) and ordinary requests are routed differently, so SMM code can see the protected memory while other code cannot.

Software controls the block through three configuration registers: an SMRAM control byte (open, lock and global-enable bits), an extended control byte (high-alias select, TSEG size code and TSEG enable), and a 16-bit extended-TSEG size register. Setting the lock bit closes the open bit and freezes both control bytes until reset. When the integration sets a nonzero extended TSEG size, the 16-bit register starts out holding a query value, and writing that query value back makes the register report the configured size in MiB.

Top module: `smram_gate`

## Requirements
- R1: After reset the SMRAM control byte (select 0) reads 0x02 and the extended control byte (select 1) reads 0x00. The size register (select 2) reads 0xFFFF when `extTsegMb` is nonzero and 0x0000 otherwise. Select 3 reads 0.
- R2: While unlocked, only bits 6 (open), 4 (lock) and 3 (global enable) of the SMRAM control byte take written values, and bits 2:0 keep reading 010. In the extended control byte only bits 7 (high select), 2:1 (TSEG size code) and 0 (TSEG enable) take written values.
- R3: A control write that leaves the lock bit set also clears the open bit in the same update. From then until reset, writes to either control byte change nothing.
- R4: For a non-SMM request, the low window routes to RAM only when open=1 and high select=0, and otherwise goes to PCI. The high alias routes to RAM only when open=1 and high select=1, and otherwise takes the default route.
- R5: For an SMM request with global enable=1, the low window is RAM when high select=0 and the high alias is RAM when high select=1. Any other SMM request routes the way a non-SMM request would, outside TSEG.
- R6: With TSEG enable=1, size codes 0, 1 and 2 give 1, 2 and 8 MiB, and code 3 gives `extTsegMb` MiB. With TSEG enable=0 the TSEG size is zero.
- R7: An address in [`below4gSize` − size, `below4gSize`) routes to the sink (route 2) for non-SMM requests and to RAM for SMM requests. `sinkRdData` is all ones while the route is the sink and zero otherwise.
- R8: With `extTsegMb` nonzero, a write of 0xFFFF to the size register makes it read back `extTsegMb`. Any other written value is stored as written. `extTsegMb` never exceeds 0xFFF.
- R9: With `extTsegMb` zero, writes to the size register are ignored and it keeps reading 0.
- R10: Outside the windows and TSEG, an address below `below4gSize` routes to RAM (route 0) and any other address routes to PCI (route 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select for write and read: 0 SMRAM control, 1 extended control, 2 size, 3 none |
| cfgWrData | input | 16 | Write data (the control bytes use bits 7:0) |
| cfgRdData | output | 16 | Combinational read data of the selected register |
| below4gSize | input | 32 | End of low memory, in bytes |
| extTsegMb | input | 16 | Configured extended TSEG size in MiB, 0 = none |
| reqAddr | input | 32 | Request address |
| reqSmm | input | 1 | Request is made in system-management mode |
| route | output | 2 | 0 RAM, 1 PCI, 2 discard sink |
| sinkRdData | output | 32 | Read data returned by the sink |

## Verification
The checks assume that `extTsegMb` stays at or below 0xFFF. They also assume it changes only while reset is held, because the size register's reset value and the query fill both depend on it. The bench therefore changes it only with `rstN` low. They further assume that `below4gSize` is at least the largest TSEG size in use and lies above the low window. The bench uses 2 GiB with 16 MiB of extended TSEG, so TSEG never overlaps either window.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int ADDR_W    = 32;
  localparam int SIZE_W    = 16;
  localparam int CTL_W     = 8;
  localparam logic [SIZE_W-1:0] QUERY_VAL = 16'hFFFF;
  localparam logic [SIZE_W-1:0] EXT_MAX   = 16'h0FFF;

  // SMRAM control byte
  localparam int BIT_OPEN  = 6;
  localparam int BIT_LOCK  = 4;
  localparam int BIT_GEN   = 3;
  localparam logic [CTL_W-1:0] CTL_RESET    = 8'h02;
  localparam logic [CTL_W-1:0] CTL_MASK_OPEN = 8'h58;
  localparam logic [CTL_W-1:0] CTL_MASK_LOCK = 8'h00;

  // Extended control byte
  localparam int BIT_HSEL  = 7;
  localparam int BIT_TEN   = 0;
  localparam logic [CTL_W-1:0] EXT_RESET     = 8'h00;
  localparam logic [CTL_W-1:0] EXT_MASK_OPEN = 8'h87;
  localparam logic [CTL_W-1:0] EXT_MASK_LOCK = 8'h00;

  // Address windows
  localparam logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] WIN_SPAN  = 32'h0002_0000;
  localparam logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000;

  typedef enum logic [1:0] {
    ROUTE_RAM  = 2'd0,
    ROUTE_PCI  = 2'd1,
    ROUTE_SINK = 2'd2
  } route_t;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_EXT  = 2'd1,
    SEL_SIZE = 2'd2,
    SEL_NONE = 2'd3
  } sel_t;

  typedef struct packed {
    logic             ctlWe;
    logic             extWe;
    logic             sizeWe;
    logic             sizeQuery;
    logic [CTL_W-1:0] ctlMask;
    logic [CTL_W-1:0] extMask;
  } strobe_t;
endpackage

// File: rtl/smram_cfg_ctrl.sv
module smram_cfg_ctrl
  import smram_pkg::*;
(
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [SIZE_W-1:0] cfgWrData,
  input  logic              lockedIn,
  input  logic [SIZE_W-1:0] extTsegMb,
  output strobe_t           strobes
);
  logic extPresent;
  assign extPresent = (extTsegMb != '0);

  always_comb begin
    strobes           = '0;
    strobes.ctlMask   = lockedIn ? CTL_MASK_LOCK : CTL_MASK_OPEN;
    strobes.extMask   = lockedIn ? EXT_MASK_LOCK : EXT_MASK_OPEN;
    if (cfgWrEn) begin
      unique case (sel_t'(cfgSel))
        SEL_CTL:  strobes.ctlWe = 1'b1;
        SEL_EXT:  strobes.extWe = 1'b1;
        SEL_SIZE: begin
          strobes.sizeWe    = extPresent;
          strobes.sizeQuery = extPresent && (cfgWrData == QUERY_VAL);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smram_datapath.sv
module smram_datapath
  import smram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [1:0]        cfgSel,
  input  logic [SIZE_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] below4gSize,
  input  logic [SIZE_W-1:0] extTsegMb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  output logic [SIZE_W-1:0] cfgRdData,
  output logic [1:0]        route,
  output logic [ADDR_W-1:0] sinkRdData,
  output logic              lockedOut,
  output logic [CTL_W-1:0]  ctlReg,
  output logic [CTL_W-1:0]  extReg,
  output logic [SIZE_W-1:0] sizeReg
);
  localparam int MB_SHIFT = 20;
  localparam int WIDE_W   = ADDR_W + 1;

  logic [CTL_W-1:0] ctlNext;

  always_comb begin
    ctlNext = (ctlReg & ~strobes.ctlMask) | (cfgWrData[CTL_W-1:0] & strobes.ctlMask);
    if (ctlNext[BIT_LOCK]) ctlNext[BIT_OPEN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= CTL_RESET;
      extReg  <= EXT_RESET;
      sizeReg <= (extTsegMb != '0) ? QUERY_VAL : '0;
    end else begin
      if (strobes.ctlWe) ctlReg <= ctlNext;
      if (strobes.extWe)
        extReg <= (extReg & ~strobes.extMask) | (cfgWrData[CTL_W-1:0] & strobes.extMask);
      if (strobes.sizeWe) sizeReg <= strobes.sizeQuery ? extTsegMb : cfgWrData;
    end
  end

  assign lockedOut = ctlReg[BIT_LOCK];

  always_comb begin
    unique case (sel_t'(cfgSel))
      SEL_CTL:  cfgRdData = {{(SIZE_W-CTL_W){1'b0}}, ctlReg};
      SEL_EXT:  cfgRdData = {{(SIZE_W-CTL_W){1'b0}}, extReg};
      SEL_SIZE: cfgRdData = sizeReg;
      default:  cfgRdData = '0;
    endcase
  end

  // TSEG size in bytes
  logic [WIDE_W-1:0] tsegBytes;
  logic [SIZE_W-1:0] tsegMb;
  always_comb begin
    unique case (extReg[2:1])
      2'd0: tsegMb = 16'd1;
      2'd1: tsegMb = 16'd2;
      2'd2: tsegMb = 16'd8;
      default: tsegMb = extTsegMb;
    endcase
    if (!extReg[BIT_TEN]) tsegMb = '0;
    tsegBytes = WIDE_W'(tsegMb) << MB_SHIFT;
  end

  logic inLow, inHigh, inTseg, belowTop;
  logic openBit, lockHsel, genBit;
  assign openBit  = ctlReg[BIT_OPEN];
  assign genBit   = ctlReg[BIT_GEN];
  assign lockHsel = extReg[BIT_HSEL];
  assign belowTop = reqAddr < below4gSize;
  assign inLow    = (reqAddr >= LOW_BASE)  && (reqAddr - LOW_BASE  < WIN_SPAN);
  assign inHigh   = (reqAddr >= HIGH_BASE) && (reqAddr - HIGH_BASE < WIN_SPAN);
  assign inTseg   = belowTop && (tsegBytes != '0) &&
                    (({1'b0, reqAddr} + tsegBytes) >= {1'b0, below4gSize});

  route_t dfltRoute, plainRoute, finalRoute;
  always_comb begin
    dfltRoute = belowTop ? ROUTE_RAM : ROUTE_PCI;
    // View of a non-SMM requester
    if (inLow)
      plainRoute = (openBit && !lockHsel) ? ROUTE_RAM : ROUTE_PCI;
    else if (inHigh)
      plainRoute = (openBit && lockHsel) ? ROUTE_RAM : dfltRoute;
    else if (inTseg)
      plainRoute = ROUTE_SINK;
    else
      plainRoute = dfltRoute;
    // SMM overlays its own view
    finalRoute = plainRoute;
    if (reqSmm) begin
      if (inTseg) finalRoute = ROUTE_RAM;
      else if (genBit && inLow && !lockHsel) finalRoute = ROUTE_RAM;
      else if (genBit && inHigh && lockHsel) finalRoute = ROUTE_RAM;
    end
  end

  assign route      = finalRoute;
  assign sinkRdData = (finalRoute == ROUTE_SINK) ? '1 : '0;
endmodule

// File: rtl/smram_gate.sv
module smram_gate
  import smram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgSel,
  input  logic [15:0] cfgWrData,
  output logic [15:0] cfgRdData,
  input  logic [31:0] below4gSize,
  input  logic [15:0] extTsegMb,
  input  logic [31:0] reqAddr,
  input  logic        reqSmm,
  output logic [1:0]  route,
  output logic [31:0] sinkRdData
);
  strobe_t           strobes;
  logic              locked;
  logic [CTL_W-1:0]  ctlReg;
  logic [CTL_W-1:0]  extReg;
  logic [SIZE_W-1:0] sizeReg;

  smram_cfg_ctrl ctrl_i (
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .lockedIn  (locked),
    .extTsegMb (extTsegMb),
    .strobes   (strobes)
  );

  smram_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgSel     (cfgSel),
    .cfgWrData  (cfgWrData),
    .below4gSize(below4gSize),
    .extTsegMb  (extTsegMb),
    .reqAddr    (reqAddr),
    .reqSmm     (reqSmm),
    .cfgRdData  (cfgRdData),
    .route      (route),
    .sinkRdData (sinkRdData),
    .lockedOut  (locked),
    .ctlReg     (ctlReg),
    .extReg     (extReg),
    .sizeReg    (sizeReg)
  );
endmodule

// File: rtl/smram_gate_chk.sv
module smram_gate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [1:0]  cfgSel,
  input logic [15:0] cfgWrData,
  input logic [15:0] extTsegMb,
  input logic [31:0] reqAddr,
  input logic        reqSmm,
  input logic [1:0]  route,
  input logic [31:0] sinkRdData,
  input logic [7:0]  ctlReg,
  input logic [7:0]  extReg,
  input logic [15:0] sizeReg
);
  logic inLowWin;
  assign inLowWin = (reqAddr >= 32'h000A_0000) && (reqAddr < 32'h000C_0000);

  assert_lock_closes_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[4] |-> !ctlReg[6]);

  assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[4] |=> (ctlReg[4] && $stable(ctlReg) && $stable(extReg)));

  assert_open_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!reqSmm && inLowWin && ctlReg[6] && !extReg[7]) |-> route == 2'd0);

  assert_closed_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!reqSmm && inLowWin && !ctlReg[6]) |-> route == 2'd1);

  assert_sink_only_plain_R7: assert property (@(posedge clk) disable iff (!rstN)
    (route == 2'd2) |-> (!reqSmm && sinkRdData == 32'hFFFF_FFFF));

  assert_query_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == 2'd2 && cfgWrData == 16'hFFFF && extTsegMb != 16'h0)
      |=> sizeReg == $past(extTsegMb));

  assert_ext_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
    extTsegMb <= 16'h0FFF);

  assert_size_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (extTsegMb == 16'h0) |-> sizeReg == 16'h0);
endmodule

bind smram_gate smram_gate_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgSel     (cfgSel),
  .cfgWrData  (cfgWrData),
  .extTsegMb  (extTsegMb),
  .reqAddr    (reqAddr),
  .reqSmm     (reqSmm),
  .route      (route),
  .sinkRdData (sinkRdData),
  .ctlReg     (ctlReg),
  .extReg     (extReg),
  .sizeReg    (sizeReg)
);

// File: tb/smram_gate_tb_top.sv
module smram_gate_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] B4G  = 32'h8000_0000;
  localparam logic [31:0] LOWA = 32'h000A_0000;
  localparam logic [31:0] HIA  = 32'hFEDA_0000;
  localparam int NVEC = 23;
  // {ctl, ext, smm, addr, expected route}
  localparam logic [50:0] VEC [0:NVEC-1] = '{
    {8'h00, 8'h00, 1'b0, LOWA, 2'd1},            // R4 closed
    {8'h40, 8'h00, 1'b0, LOWA, 2'd0},            // R4 open low
    {8'h40, 8'h80, 1'b0, LOWA, 2'd1},            // R4 hidden low
    {8'h40, 8'h80, 1'b0, HIA,  2'd0},            // R4 high open
    {8'h40, 8'h00, 1'b0, HIA,  2'd1},            // R4 high closed
    {8'h00, 8'h80, 1'b0, HIA,  2'd1},            // R4
    {8'h08, 8'h00, 1'b1, LOWA, 2'd0},            // R5 smm low
    {8'h08, 8'h80, 1'b1, HIA,  2'd0},            // R5 smm high
    {8'h08, 8'h80, 1'b1, LOWA, 2'd1},            // R5 smm low hidden
    {8'h00, 8'h00, 1'b1, LOWA, 2'd1},            // R5 no gen
    {8'h00, 8'h80, 1'b1, HIA,  2'd1},            // R5 no gen high
    {8'h00, 8'h01, 1'b0, 32'h7FF0_0000, 2'd2},   // R6 1MiB in
    {8'h00, 8'h01, 1'b0, 32'h7FE0_0000, 2'd0},   // R6 1MiB out
    {8'h00, 8'h03, 1'b0, 32'h7FE0_0000, 2'd2},   // R6 2MiB in
    {8'h00, 8'h05, 1'b0, 32'h7F80_0000, 2'd2},   // R6 8MiB in
    {8'h00, 8'h05, 1'b0, 32'h7F70_0000, 2'd0},   // R6 8MiB out
    {8'h00, 8'h07, 1'b0, 32'h7F00_0000, 2'd2},   // R6 ext 16MiB in
    {8'h00, 8'h07, 1'b1, 32'h7F00_0000, 2'd0},   // R7 smm tseg
    {8'h00, 8'h06, 1'b0, 32'h7FF0_0000, 2'd0},   // R6 disabled
    {8'h00, 8'h00, 1'b0, 32'h0010_0000, 2'd0},   // R10 ram
    {8'h00, 8'h00, 1'b0, 32'hC000_0000, 2'd1},   // R10 pci
    {8'h00, 8'h07, 1'b0, B4G,           2'd1},   // R10 top edge
    {8'h40, 8'h00, 1'b1, LOWA, 2'd0}             // R5 falls back to plain view
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [15:0] cfgWrData = 16'h0;
  logic [15:0] cfgRdData;
  logic [31:0] below4gSize = B4G;
  logic [15:0] extTsegMb = 16'h0010;
  logic [31:0] reqAddr = 32'h0;
  logic        reqSmm = 1'b0;
  logic [1:0]  route;
  logic [31:0] sinkRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_gate dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .below4gSize(below4gSize),
    .extTsegMb(extTsegMb), .reqAddr(reqAddr), .reqSmm(reqSmm),
    .route(route), .sinkRdData(sinkRdData)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] sel, input logic [15:0] exp);
    cfgSel = sel;
    #1;
    check(tag, {16'h0, cfgRdData}, {16'h0, exp});
  endtask

  task automatic req(input string tag, input logic smm, input logic [31:0] a,
                     input logic [1:0] exp);
    reqSmm = smm; reqAddr = a;
    #1;
    check(tag, {30'h0, route}, {30'h0, exp});
  endtask

  task automatic doReset(input logic [15:0] ext);
    @(negedge clk);
    rstN = 1'b0;
    extTsegMb = ext;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd("R1 ctl reset", 2'd0, 16'h0002);
    rd("R1 ext reset", 2'd1, 16'h0000);
    rd("R1 size reset query", 2'd2, 16'hFFFF);
    rd("R1 none reads zero", 2'd3, 16'h0000);
    req("R1 low closed after reset", 1'b0, LOWA, 2'd1);

    // Table walk: R4 R5 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, {8'h00, VEC[i][50:43]});
      wr(2'd1, {8'h00, VEC[i][42:35]});
      req($sformatf("R4/R5/R6/R10 vector %0d", i), VEC[i][34], VEC[i][33:2], VEC[i][1:0]);
    end

    // R7 sink data
    wr(2'd1, 16'h0001);
    req("R7 sink route", 1'b0, 32'h7FF8_0000, 2'd2);
    check("R7 sink data ones", sinkRdData, 32'hFFFF_FFFF);
    req("R7 smm tseg ram", 1'b1, 32'h7FF8_0000, 2'd0);
    check("R7 sink data zero off-sink", sinkRdData, 32'h0);

    // R2 write masks
    wr(2'd0, 16'h00EF);
    rd("R2 ctl mask", 2'd0, 16'h004A);
    wr(2'd1, 16'h00FF);
    rd("R2 ext mask", 2'd1, 16'h0087);

    // R8 size query handshake
    wr(2'd2, 16'hFFFF);
    rd("R8 query fills size", 2'd2, 16'h0010);
    wr(2'd2, 16'h1234);
    rd("R8 plain value stored", 2'd2, 16'h1234);
    wr(2'd2, 16'hFFFF);
    rd("R8 query again", 2'd2, 16'h0010);

    // R3 lock
    wr(2'd1, 16'h0081);
    wr(2'd0, 16'h0058);
    rd("R3 lock clears open", 2'd0, 16'h001A);
    wr(2'd0, 16'h0048);
    rd("R3 ctl frozen", 2'd0, 16'h001A);
    wr(2'd1, 16'h0000);
    rd("R3 ext frozen", 2'd1, 16'h0081);
    req("R3 low stays closed", 1'b0, LOWA, 2'd1);
    req("R3 smm high still ram", 1'b1, HIA, 2'd0);
    doReset(16'h0010);
    rd("R3 lock cleared by reset", 2'd0, 16'h0002);

    // R9 no extended size configured
    doReset(16'h0000);
    rd("R9 size reset zero", 2'd2, 16'h0000);
    wr(2'd2, 16'hFFFF);
    rd("R9 query ignored", 2'd2, 16'h0000);
    wr(2'd2, 16'h0055);
    rd("R9 write ignored", 2'd2, 16'h0000);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule